// File: doc/BRIEF.md
# Instruction Decoder and Control Unit

This block takes one 32-bit instruction word of a small load/store processor with sixteen 16-bit registers. It produces the control bundle that steers one instruction through a single-cycle datapath. It also cuts the word into its operand fields: the two source register addresses, the destination register address, the shift amount, a 16-bit immediate and a 10-bit jump target. The register file, ALU, memories and next-PC arithmetic sit outside the block and use these outputs.

Three word formats share a 6-bit major opcode at the top of the word. Register-format words choose their operation through a 6-bit function field. Immediate-format words carry the full 16-bit constant, so a load-immediate instruction can put a whole register value in place without any ALU work. Jump-format words carry a 10-bit word address. Unused low bits of each format must be zero. A word that breaks this rule, or that has an unknown opcode or function, is treated as illegal: it writes nothing and redirects nothing.

All outputs are registered and appear one clock after the word is applied. A synchronous active-high reset clears every output to zero.

Top module: `instr_decoder`

## Requirements
- R1: One cycle after a word `w` is applied, the field outputs equal rs=w[25:22], rt=w[21:18], rd=w[17:14], shamt=w[13:10], imm=w[17:2] and jtarget=w[25:16], whatever the opcode.
- R2: While reset is high at a clock edge, every output is zero after that edge.
- R3: With opcode 0x00, low bits [3:0] zero and func add=0x20, sub=0x22, and=0x24, or=0x25 or slt=0x2A, the block asserts write enable with destination select rd (code 0), register ALU source (0) and write-back from the ALU (code 0). The ALU operation code is add=0, sub=1, and=2, or=3, slt=4.
- R4: With opcode 0x00, func sll=0x00 or srl=0x02 and low bits zero, the block writes rd from the ALU with ALU operation 5 (sll) or 6 (srl) and a register ALU source.
- R5: addi (0x08), slti (0x0A), andi (0x0C) and ori (0x0D) write rt (destination code 1) from the ALU with the immediate ALU source (1) and operations 0, 4, 2 and 3.
- R6: lw (0x23) writes rt with memory read, write-back code 1, immediate source and ALU add. sw (0x2B) asserts memory write and immediate source, and neither writes a register nor reads memory.
- R7: beq (0x04) and bne (0x05) give branch type 1 and 2, with ALU operation sub and no register or memory write.
- R8: li (0x0F) writes rt with write-back code 2 (immediate), register ALU source, ALU operation 0 and no memory access.
- R9: j (0x02) gives jump type 1. jal (0x03) gives jump type 1, link, write enable, destination code 2 (link register) and write-back code 3. jr (opcode 0x00, func 0x08) gives jump type 2 and writes nothing.
- R10: An unknown opcode, or opcode 0x00 with an unknown func, drives every control output to zero: no register write, no memory access, no branch and no jump.
- R11: A nonzero reserved bit makes the word illegal and gives the same all-zero controls as R10. The reserved bits are [3:0] for register format, [1:0] for immediate format and [15:0] for jump format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| wr_en_o | output | 1 | Register write enable |
| dst_sel_o | output | 2 | Destination: 0 rd, 1 rt, 2 link register |
| alu_imm_o | output | 1 | ALU second operand is the immediate |
| alu_op_o | output | 4 | ALU operation code |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 immediate, 3 return address |
| branch_o | output | 2 | Branch type: 0 none, 1 equal, 2 not equal |
| jump_o | output | 2 | Jump type: 0 none, 1 target, 2 register |
| link_o | output | 1 | Save return address |
| rs_o | output | 4 | First source register |
| rt_o | output | 4 | Second source / immediate destination register |
| rd_o | output | 4 | Register-format destination |
| shamt_o | output | 4 | Shift amount |
| imm_o | output | 16 | Immediate |
| jtarget_o | output | 10 | Jump word address |

## Verification
The bench builds the block with its default parameters: 4-bit register addresses, 4-bit shift amount, 16-bit immediate and 10-bit jump target in a 32-bit word. This is the only layout in which the fixed opcode and function codes are defined. With these values the bench reaches every supported instruction, and immediates and shift amounts at their all-ones extremes. It also reaches unknown opcodes and functions, and words with a set bit in each format's reserved region. A reset during operation with a legal jump-and-link word on the input shows that reset outranks decoding.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int OPC_W = 6;
  localparam int FUN_W = 6;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_J    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JAL  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LI   = 6'h0F;
  localparam logic [OPC_W-1:0] OPC_LW   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW   = 6'h2B;

  localparam logic [FUN_W-1:0] FN_SLL = 6'h00;
  localparam logic [FUN_W-1:0] FN_SRL = 6'h02;
  localparam logic [FUN_W-1:0] FN_JR  = 6'h08;
  localparam logic [FUN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUN_W-1:0] FN_AND = 6'h24;
  localparam logic [FUN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {DST_RD = 2'd0, DST_RT = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_SLT = 4'd4, ALU_SLL = 4'd5, ALU_SRL = 4'd6
  } aluop_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_IMM = 2'd2, WB_RET = 2'd3} wb_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2} br_e;
  typedef enum logic [1:0] {JP_NONE = 2'd0, JP_TGT = 2'd1, JP_REG = 2'd2} jmp_e;

  typedef struct packed {
    logic   we;
    dst_e   dst;
    logic   asrc;
    aluop_e aop;
    logic   mrd;
    logic   mwr;
    wb_e    wb;
    br_e    br;
    jmp_e   jmp;
    logic   lnk;
  } ctrl_t;

endpackage

// File: rtl/idec_fields.sv
module idec_fields #(
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 4,
  parameter int SH_W    = 4,
  parameter int IMM_W   = 16,
  parameter int JA_W    = 10
) (
  input  logic [INSTR_W-1:0]         word_i,
  output logic [idec_pkg::OPC_W-1:0] op_o,
  output logic [idec_pkg::FUN_W-1:0] fn_o,
  output logic [REG_AW-1:0]          rs_o,
  output logic [REG_AW-1:0]          rt_o,
  output logic [REG_AW-1:0]          rd_o,
  output logic [SH_W-1:0]            sh_o,
  output logic [IMM_W-1:0]           imm_o,
  output logic [JA_W-1:0]            jt_o,
  output logic [INSTR_W-idec_pkg::OPC_W-JA_W-1:0] low_o
);
  localparam int OP_LO  = INSTR_W - idec_pkg::OPC_W;
  localparam int RS_LO  = OP_LO - REG_AW;
  localparam int RT_LO  = RS_LO - REG_AW;
  localparam int RD_LO  = RT_LO - REG_AW;
  localparam int SH_LO  = RD_LO - SH_W;
  localparam int FN_LO  = SH_LO - idec_pkg::FUN_W;
  localparam int IMM_LO = RT_LO - IMM_W;
  localparam int JA_LO  = OP_LO - JA_W;

  assign op_o  = word_i[INSTR_W-1:OP_LO];
  assign rs_o  = word_i[OP_LO-1:RS_LO];
  assign rt_o  = word_i[RS_LO-1:RT_LO];
  assign rd_o  = word_i[RT_LO-1:RD_LO];
  assign sh_o  = word_i[RD_LO-1:SH_LO];
  assign fn_o  = word_i[SH_LO-1:FN_LO];
  assign imm_o = word_i[RT_LO-1:IMM_LO];
  assign jt_o  = word_i[OP_LO-1:JA_LO];
  assign low_o = word_i[JA_LO-1:0];
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl #(
  parameter int LOW_W   = 16,
  parameter int PAD_R_W = 4,
  parameter int PAD_I_W = 2
) (
  input  logic [idec_pkg::OPC_W-1:0] op_i,
  input  logic [idec_pkg::FUN_W-1:0] fn_i,
  input  logic [LOW_W-1:0]           low_i,
  output idec_pkg::ctrl_t            ctl_o,
  output logic                       known_o
);
  import idec_pkg::*;

  logic pad_r_ok, pad_i_ok, pad_j_ok;
  assign pad_r_ok = (low_i[PAD_R_W-1:0] == '0);
  assign pad_i_ok = (low_i[PAD_I_W-1:0] == '0);
  assign pad_j_ok = (low_i == '0);

  always_comb begin
    ctl_o   = '0;
    known_o = 1'b0;
    case (op_i)
      OPC_REG: if (pad_r_ok) begin
        known_o   = 1'b1;
        ctl_o.we  = 1'b1;
        ctl_o.dst = DST_RD;
        case (fn_i)
          FN_ADD: ctl_o.aop = ALU_ADD;
          FN_SUB: ctl_o.aop = ALU_SUB;
          FN_AND: ctl_o.aop = ALU_AND;
          FN_OR:  ctl_o.aop = ALU_OR;
          FN_SLT: ctl_o.aop = ALU_SLT;
          FN_SLL: ctl_o.aop = ALU_SLL;
          FN_SRL: ctl_o.aop = ALU_SRL;
          FN_JR: begin
            ctl_o.we  = 1'b0;
            ctl_o.jmp = JP_REG;
          end
          default: begin
            ctl_o   = '0;
            known_o = 1'b0;
          end
        endcase
      end
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_LW: if (pad_i_ok) begin
        known_o    = 1'b1;
        ctl_o.we   = 1'b1;
        ctl_o.dst  = DST_RT;
        ctl_o.asrc = 1'b1;
        case (op_i)
          OPC_SLTI: ctl_o.aop = ALU_SLT;
          OPC_ANDI: ctl_o.aop = ALU_AND;
          OPC_ORI:  ctl_o.aop = ALU_OR;
          OPC_LW: begin
            ctl_o.mrd = 1'b1;
            ctl_o.wb  = WB_MEM;
          end
          default: ctl_o.aop = ALU_ADD;
        endcase
      end
      OPC_SW: if (pad_i_ok) begin
        known_o    = 1'b1;
        ctl_o.asrc = 1'b1;
        ctl_o.mwr  = 1'b1;
      end
      OPC_BEQ, OPC_BNE: if (pad_i_ok) begin
        known_o   = 1'b1;
        ctl_o.aop = ALU_SUB;
        ctl_o.br  = (op_i == OPC_BEQ) ? BR_EQ : BR_NE;
      end
      OPC_LI: if (pad_i_ok) begin
        known_o   = 1'b1;
        ctl_o.we  = 1'b1;
        ctl_o.dst = DST_RT;
        ctl_o.wb  = WB_IMM;
      end
      OPC_J: if (pad_j_ok) begin
        known_o   = 1'b1;
        ctl_o.jmp = JP_TGT;
      end
      OPC_JAL: if (pad_j_ok) begin
        known_o   = 1'b1;
        ctl_o.jmp = JP_TGT;
        ctl_o.lnk = 1'b1;
        ctl_o.we  = 1'b1;
        ctl_o.dst = DST_LINK;
        ctl_o.wb  = WB_RET;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder #(
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 4,
  parameter int SH_W    = 4,
  parameter int IMM_W   = 16,
  parameter int JA_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               wr_en_o,
  output logic [1:0]         dst_sel_o,
  output logic               alu_imm_o,
  output logic [3:0]         alu_op_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [1:0]         wb_sel_o,
  output logic [1:0]         branch_o,
  output logic [1:0]         jump_o,
  output logic               link_o,
  output logic [REG_AW-1:0]  rs_o,
  output logic [REG_AW-1:0]  rt_o,
  output logic [REG_AW-1:0]  rd_o,
  output logic [SH_W-1:0]    shamt_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [JA_W-1:0]    jtarget_o
);
  import idec_pkg::*;

  localparam int LOW_W   = INSTR_W - OPC_W - JA_W;
  localparam int OP_LO   = INSTR_W - OPC_W;
  localparam int RS_LO   = OP_LO - REG_AW;
  localparam int RT_LO   = RS_LO - REG_AW;
  localparam int RD_LO   = RT_LO - REG_AW;
  localparam int PAD_R_W = RD_LO - SH_W - FUN_W;
  localparam int PAD_I_W = RT_LO - IMM_W;

  logic [OPC_W-1:0]  op;
  logic [FUN_W-1:0]  fn;
  logic [REG_AW-1:0] rs, rt, rd;
  logic [SH_W-1:0]   sh;
  logic [IMM_W-1:0]  imm;
  logic [JA_W-1:0]   jt;
  logic [LOW_W-1:0]  low;
  ctrl_t             ctl_d, ctl_q;
  logic              known;

  idec_fields #(
    .INSTR_W(INSTR_W), .REG_AW(REG_AW), .SH_W(SH_W), .IMM_W(IMM_W), .JA_W(JA_W)
  ) u_fields (
    .word_i(instr_i), .op_o(op), .fn_o(fn), .rs_o(rs), .rt_o(rt), .rd_o(rd),
    .sh_o(sh), .imm_o(imm), .jt_o(jt), .low_o(low)
  );

  idec_ctrl #(
    .LOW_W(LOW_W), .PAD_R_W(PAD_R_W), .PAD_I_W(PAD_I_W)
  ) u_ctrl (
    .op_i(op), .fn_i(fn), .low_i(low), .ctl_o(ctl_d), .known_o(known)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      rs_o      <= '0;
      rt_o      <= '0;
      rd_o      <= '0;
      shamt_o   <= '0;
      imm_o     <= '0;
      jtarget_o <= '0;
    end else begin
      ctl_q     <= ctl_d;
      rs_o      <= rs;
      rt_o      <= rt;
      rd_o      <= rd;
      shamt_o   <= sh;
      imm_o     <= imm;
      jtarget_o <= jt;
    end
  end

  assign wr_en_o   = ctl_q.we;
  assign dst_sel_o = ctl_q.dst;
  assign alu_imm_o = ctl_q.asrc;
  assign alu_op_o  = ctl_q.aop;
  assign mem_rd_o  = ctl_q.mrd;
  assign mem_wr_o  = ctl_q.mwr;
  assign wb_sel_o  = ctl_q.wb;
  assign branch_o  = ctl_q.br;
  assign jump_o    = ctl_q.jmp;
  assign link_o    = ctl_q.lnk;

  p_fields_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rs_o == $past(instr_i[OP_LO-1:RS_LO]) && imm_o == $past(instr_i[RT_LO-1:PAD_I_W])));

  p_mem_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  p_store_nowr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> !wr_en_o);

  p_li_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_sel_o == 2'd2) |-> (wr_en_o && dst_sel_o == 2'd1 && !mem_rd_o && !mem_wr_o));

  p_flow_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(branch_o != 2'd0 && jump_o != 2'd0));

  p_link_r9: assert property (@(posedge clk) disable iff (rst)
    link_o |-> (wr_en_o && dst_sel_o == 2'd2 && wb_sel_o == 2'd3 && jump_o == 2'd1));

  p_illegal_r10: assert property (@(posedge clk) disable iff (rst)
    !known |=> (!wr_en_o && !mem_wr_o && !mem_rd_o && branch_o == 2'd0 && jump_o == 2'd0));

endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr;
  logic        wr_en, alu_imm, mem_rd, mem_wr, link;
  logic [1:0]  dst_sel, wb_sel, branch, jump;
  logic [3:0]  alu_op, rs, rt, rd, shamt;
  logic [15:0] imm;
  logic [9:0]  jtarget;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_decoder u_dut (
    .clk(clk), .rst(rst), .instr_i(instr),
    .wr_en_o(wr_en), .dst_sel_o(dst_sel), .alu_imm_o(alu_imm), .alu_op_o(alu_op),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .wb_sel_o(wb_sel), .branch_o(branch),
    .jump_o(jump), .link_o(link), .rs_o(rs), .rt_o(rt), .rd_o(rd),
    .shamt_o(shamt), .imm_o(imm), .jtarget_o(jtarget)
  );

  typedef struct {
    logic [31:0] w;
    logic [16:0] ctl;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [3:0] s, logic [3:0] t,
                                        logic [3:0] d, logic [3:0] sh);
    return {6'h00, s, t, d, sh, fn, 4'h0};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [3:0] s, logic [3:0] t,
                                        logic [15:0] k);
    return {op, s, t, k, 2'b00};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [9:0] a);
    return {op, a, 16'h0000};
  endfunction
  function automatic logic [16:0] mk(logic we, logic [1:0] dst, logic asrc, logic [3:0] aop,
                                     logic mrd, logic mwr, logic [1:0] wb, logic [1:0] br,
                                     logic [1:0] jmp, logic lnk);
    return {we, dst, asrc, aop, mrd, mwr, wb, br, jmp, lnk};
  endfunction

  function automatic logic [16:0] act_ctl();
    return {wr_en, dst_sel, alu_imm, alu_op, mem_rd, mem_wr, wb_sel, branch, jump, link};
  endfunction

  task automatic push(logic [31:0] w, logic [16:0] c, string req);
    item_t it;
    @(negedge clk);
    instr  = w;
    it.w   = w;
    it.ctl = c;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: each queued word is registered at the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [41:0] fexp, fact;
        it = q.pop_front();
        n_chk++;
        if (act_ctl() !== it.ctl) begin
          n_bad++;
          $display("FAIL %s controls: word %h actual %h expected %h", it.req, it.w, act_ctl(), it.ctl);
        end
        fexp = {it.w[25:22], it.w[21:18], it.w[17:14], it.w[13:10], it.w[17:2], it.w[25:16]};
        fact = {rs, rt, rd, shamt, imm, jtarget};
        n_chk++;
        if (fact !== fexp) begin
          n_bad++;
          $display("FAIL R1 fields: word %h actual %h expected %h", it.w, fact, fexp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic check_reset_zero(string tag);
    logic [58:0] a;
    a = {act_ctl(), rs, rt, rd, shamt, imm, jtarget};
    n_chk++;
    if (a !== '0) begin
      n_bad++;
      $display("FAIL %s reset state: actual %h expected 0", tag, a);
    end
  endtask

  initial begin
    rst   = 1'b1;
    instr = enc_r(6'h20, 4'd3, 4'd5, 4'd9, 4'd2);
    repeat (3) @(posedge clk);
    #1;
    check_reset_zero("R2");
    @(negedge clk);
    rst = 1'b0;

    // R3 register-format ALU ops
    push(enc_r(6'h20, 4'd1, 4'd2, 4'd3, 4'd0), mk(1,0,0,4'd0,0,0,0,0,0,0), "R3 add");
    push(enc_r(6'h22, 4'd15, 4'd14, 4'd13, 4'd0), mk(1,0,0,4'd1,0,0,0,0,0,0), "R3 sub");
    push(enc_r(6'h24, 4'd4, 4'd5, 4'd6, 4'd0), mk(1,0,0,4'd2,0,0,0,0,0,0), "R3 and");
    push(enc_r(6'h25, 4'd7, 4'd8, 4'd9, 4'd0), mk(1,0,0,4'd3,0,0,0,0,0,0), "R3 or");
    push(enc_r(6'h2A, 4'd10, 4'd11, 4'd12, 4'd0), mk(1,0,0,4'd4,0,0,0,0,0,0), "R3 slt");
    // R4 shifts
    push(enc_r(6'h00, 4'd0, 4'd2, 4'd1, 4'd7), mk(1,0,0,4'd5,0,0,0,0,0,0), "R4 sll");
    push(enc_r(6'h02, 4'd0, 4'd3, 4'd4, 4'd15), mk(1,0,0,4'd6,0,0,0,0,0,0), "R4 srl");
    // R5 immediate ALU ops
    push(enc_i(6'h08, 4'd2, 4'd1, 16'hFFFF), mk(1,1,1,4'd0,0,0,0,0,0,0), "R5 addi");
    push(enc_i(6'h0A, 4'd3, 4'd4, 16'h0064), mk(1,1,1,4'd4,0,0,0,0,0,0), "R5 slti");
    push(enc_i(6'h0C, 4'd5, 4'd6, 16'h00F0), mk(1,1,1,4'd2,0,0,0,0,0,0), "R5 andi");
    push(enc_i(6'h0D, 4'd7, 4'd8, 16'h8001), mk(1,1,1,4'd3,0,0,0,0,0,0), "R5 ori");
    // R6 memory
    push(enc_i(6'h23, 4'd2, 4'd1, 16'h0064), mk(1,1,1,4'd0,1,0,1,0,0,0), "R6 lw");
    push(enc_i(6'h2B, 4'd2, 4'd1, 16'hFF9C), mk(0,0,1,4'd0,0,1,0,0,0,0), "R6 sw");
    // R7 branches
    push(enc_i(6'h04, 4'd1, 4'd2, 16'h0010), mk(0,0,0,4'd1,0,0,0,1,0,0), "R7 beq");
    push(enc_i(6'h05, 4'd3, 4'd4, 16'hFFFE), mk(0,0,0,4'd1,0,0,0,2,0,0), "R7 bne");
    // R8 load immediate
    push(enc_i(6'h0F, 4'd0, 4'd9, 16'hBEEF), mk(1,1,0,4'd0,0,0,2,0,0,0), "R8 li");
    // R9 jumps
    push(enc_j(6'h02, 10'd1000), mk(0,0,0,4'd0,0,0,0,0,1,0), "R9 j");
    push(enc_j(6'h03, 10'h3FF), mk(1,2,0,4'd0,0,0,3,0,1,1), "R9 jal");
    push(enc_r(6'h08, 4'd15, 4'd0, 4'd0, 4'd0), mk(0,0,0,4'd0,0,0,0,0,2,0), "R9 jr");
    // R10 unknown opcode / func
    push(enc_i(6'h3F, 4'd1, 4'd2, 16'h1234), '0, "R10 bad opcode");
    push(enc_r(6'h3F, 4'd1, 4'd2, 4'd3, 4'd0), '0, "R10 bad func");
    push(enc_i(6'h01, 4'd4, 4'd5, 16'h0000), '0, "R10 bad opcode 01");
    // R11 reserved bits
    push(enc_r(6'h20, 4'd1, 4'd2, 4'd3, 4'd0) | 32'h1, '0, "R11 reg pad");
    push(enc_i(6'h23, 4'd2, 4'd1, 16'h0064) | 32'h2, '0, "R11 imm pad");
    push(enc_j(6'h03, 10'd5) | 32'h8, '0, "R11 jump pad");
    push(enc_j(6'h02, 10'd5) | 32'h8000, '0, "R11 jump pad top");

    wait (q.size() == 0);
    @(posedge clk);
    // R2 reset during operation outranks a legal word
    @(negedge clk);
    instr = enc_j(6'h03, 10'd77);
    rst   = 1'b1;
    @(posedge clk);
    #1;
    check_reset_zero("R2 mid-run");
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule